// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block moves data synchronously between a 12-bit narrow port (A) and a 24-bit wide port (B). The wide port is made of two 12-bit halves. The upper half, bits 23:12, is called 1B. The lower half, bits 11:0, is called 2B. In the narrow-to-wide direction, the first narrow word passes through a front register and then a second register on its way to the upper half. The following word goes through a single register into the lower half. Two back-to-back narrow words therefore appear together as one wide word.

In the wide-to-narrow direction, each half is captured in its own register under its own enable. A registered select chooses which stored half drives the narrow port. Both output enables are active low and are captured on the clock, so any change of bus direction takes effect at a rising edge.

Each three-state port is modelled as three signals: a data output, a drive-enable output and a separate sampled input. This keeps the block free of internal three-state nets. An optional synchronous active-low reset parks both drive enables in the disabled state. When the reset is left unused, the drive state before the first edge is undefined.

Top module: `nwx_exchanger`

## Requirements
- R1: Wide-port mapping is fixed. The 1B half is `b_out[23:12]` and `b_in[23:12]`. The 2B half is `b_out[11:0]` and `b_in[11:0]`. A registered select of 0 picks the 1B store for `a_out`, and 1 picks the 2B store.
- R2: The front register of the 1B path captures `a_in` on a rising edge when `ce_a1_n` is low. Otherwise it holds its value, whatever `a_in` does.
- R3: On a rising edge with `ce_ab_n` low, the 1B half of `b_out` takes the front register's value. On the same edge, the 2B half takes `a_in`. With `ce_ab_n` high, `b_out` holds.
- R4: Word X is presented with `ce_a1_n` low. On the next edge, word Y is presented with `ce_ab_n` low. Right after that second edge, `b_out` equals {X, Y}.
- R5: The 1B store toward A captures `b_in[23:12]` on an edge with `ce_ba1_n` low. The 2B store captures `b_in[11:0]` on an edge with `ce_ba2_n` low. Each store holds while its enable is high.
- R6: `sel_2b` is captured on every rising edge. A change on it alters `a_out` only after the next rising edge.
- R7: `a_oe` becomes the inverse of `oea_n` as it was at the last rising edge, and `b_oe` likewise follows `oeb_n`. Between edges, both stay unchanged.
- R8: An edge with `rst_n` low forces `a_oe` and `b_oe` to 0. The data stores are not affected by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the drive enables |
| a_in | input | 12 | Sampled value of the narrow port |
| a_out | output | 12 | Data to drive onto the narrow port |
| a_oe | output | 1 | Narrow-port drive enable, active high |
| b_in | input | 24 | Sampled value of the wide port |
| b_out | output | 24 | Data to drive onto the wide port |
| b_oe | output | 1 | Wide-port drive enable, active high |
| ce_a1_n | input | 1 | Active-low load of the 1B front register |
| ce_ab_n | input | 1 | Active-low joint load of both wide-port halves |
| ce_ba1_n | input | 1 | Active-low load of the 1B store toward A |
| ce_ba2_n | input | 1 | Active-low load of the 2B store toward A |
| sel_2b | input | 1 | Half select for the narrow output, captured on the clock |
| oea_n | input | 1 | Active-low narrow-port output enable, registered |
| oeb_n | input | 1 | Active-low wide-port output enable, registered |

## Verification
Every output of this block sits exactly one register away from the input that controls it, except the 1B data path. A word enters that path at the front-register edge and reaches `b_out` at the following joint-load edge. The bench drives inputs on the falling edge and advances its expected-value model at the rising edge. It then compares all outputs at the next falling edge, which is the first point where the result of that edge is due.

For the select and output-enable cases, the bench also checks the outputs after the input has changed but before the next rising edge. The old value must still be present there.

// File: rtl/nwx_pkg.sv
// Package nwx_pkg
// Purpose : shared types and helpers for the narrow-to-wide bus exchanger.
// Assumes : the wide port always carries exactly two narrow halves.
package nwx_pkg;

    // Default narrow word width.
    localparam int NWX_NARROW_W = 12;

    // Number of narrow halves in one wide word.
    localparam int NWX_HALVES = 2;

    // Index of each half within the per-half arrays.
    // Upper half (1B) is index 1 and lower half (2B) is index 0, matching bit order.
    localparam int NWX_IDX_1B = 1;
    localparam int NWX_IDX_2B = 0;

    // Encoding of the narrow-output half select.
    typedef enum logic {
        HALF_1B = 1'b0,
        HALF_2B = 1'b1
    } half_sel_e;

    // Turn an active-low enable into an active-high load strobe.
    function automatic logic load_from_n(input logic ce_n);
        return ~ce_n;
    endfunction

endpackage

// File: rtl/nwx_a2b_path.sv
// Module nwx_a2b_path
// Purpose : narrow-to-wide data path.
//           The 1B half goes through two register stages (front, then wide).
//           The 2B half goes through a single register stage.
// Assumes : rst_n is used only to qualify the assertions.
//           The data registers carry no reset.
module nwx_a2b_path
    import nwx_pkg::*;
#(
    parameter int W = NWX_NARROW_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic         ce_front_n,
    input  logic         ce_wide_n,
    output logic [W-1:0] wide_hi,
    output logic [W-1:0] wide_lo
);

    logic [W-1:0] front_q;
    logic [W-1:0] hi_q;
    logic [W-1:0] lo_q;
    logic         front_ld;
    logic         wide_ld;

    // Decode the active-low enables into load strobes.
    always_comb begin
        front_ld = load_from_n(ce_front_n);
        wide_ld  = load_from_n(ce_wide_n);
    end

    // Front stage of the 1B pipeline: capture the narrow word when enabled.
    always_ff @(posedge clk) begin
        if (front_ld) begin
            front_q <= a_in;
        end
    end

    // Wide stage: both halves load on the same edge.
    always_ff @(posedge clk) begin
        if (wide_ld) begin
            hi_q <= front_q;
            lo_q <= a_in;
        end
    end

    // Drive the wide-port halves from the wide stage.
    always_comb begin
        wide_hi = hi_q;
        wide_lo = lo_q;
    end

    AST_WIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ce_wide_n |=> ($stable(wide_hi) && $stable(wide_lo))) else $error("wide hold");   // R3

    AST_LO_TAKES_A: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_wide_n |=> (wide_lo == $past(a_in))) else $error("lo load");                  // R3

    AST_PAIR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_front_n ##1 !ce_wide_n) |=> (wide_hi == $past(a_in, 2))) else $error("pair");   // R4

endmodule

// File: rtl/nwx_b2a_path.sv
// Module nwx_b2a_path
// Purpose : wide-to-narrow path.
//           Each half has its own store and its own enable.
//           A select captured on every edge picks the store that drives the narrow port.
// Assumes : bit order of b_in follows {1B, 2B}.
//           The stores carry no reset.
module nwx_b2a_path
    import nwx_pkg::*;
#(
    parameter int W = NWX_NARROW_W,
    localparam int WW = W * NWX_HALVES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [WW-1:0] b_in,
    input  logic          ce_1b_n,
    input  logic          ce_2b_n,
    input  logic          sel_2b,
    output logic [W-1:0]  a_out
);

    logic [NWX_HALVES-1:0] ce_n_vec;
    logic [W-1:0]          store_q [NWX_HALVES];
    half_sel_e             sel_q;

    // Gather the per-half enables into a vector indexed like the data halves.
    always_comb begin
        ce_n_vec[NWX_IDX_1B] = ce_1b_n;
        ce_n_vec[NWX_IDX_2B] = ce_2b_n;
    end

    // One capture register per half of the wide port.
    for (genvar h = 0; h < NWX_HALVES; h++) begin : g_half
        // Capture this half of b_in when its enable is low.
        always_ff @(posedge clk) begin
            if (load_from_n(ce_n_vec[h])) begin
                store_q[h] <= b_in[h*W +: W];
            end
        end

        AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            ce_n_vec[h] |=> $stable(store_q[h])) else $error("store hold");   // R5
    end

    // Select register: captured on every edge, no enable.
    always_ff @(posedge clk) begin
        sel_q <= half_sel_e'(sel_2b);
    end

    // Route the chosen store to the narrow output.
    always_comb begin
        if (sel_q == HALF_2B) begin
            a_out = store_q[NWX_IDX_2B];
        end else begin
            a_out = store_q[NWX_IDX_1B];
        end
    end

    AST_A_FROM_1B: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_1b_n && !sel_2b) |=> (a_out == $past(b_in[WW-1:W]))) else $error("1B to A");   // R5

    AST_A_FROM_2B: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_2b_n && sel_2b) |=> (a_out == $past(b_in[W-1:0]))) else $error("2B to A");     // R6

endmodule

// File: rtl/nwx_oe_ctrl.sv
// Module nwx_oe_ctrl
// Purpose : registers the two active-low output enables.
//           Produces active-high drive enables for the port pads.
// Assumes : with USE_RESET = 0 the reset input is ignored.
//           The drive state is then undefined until the first edge.
module nwx_oe_ctrl #(
    parameter bit USE_RESET = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oea_n,
    input  logic oeb_n,
    output logic a_oe,
    output logic b_oe
);

    logic oea_q;
    logic oeb_q;

    // Choose the register variant: with or without the parking reset.
    if (USE_RESET) begin : g_rst
        // Capture the enables; reset parks both enables in the disabled (high) state.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                oea_q <= 1'b1;
                oeb_q <= 1'b1;
            end else begin
                oea_q <= oea_n;
                oeb_q <= oeb_n;
            end
        end

        AST_RESET_PARKS: assert property (@(posedge clk)
            !rst_n |=> (!a_oe && !b_oe)) else $error("reset park");   // R8
    end else begin : g_nrst
        // Capture the enables with no reset at all.
        always_ff @(posedge clk) begin
            oea_q <= oea_n;
            oeb_q <= oeb_n;
        end
    end

    // Turn the registered active-low enables into active-high drive enables.
    always_comb begin
        a_oe = ~oea_q;
        b_oe = ~oeb_q;
    end

    AST_OE_A_REG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (a_oe == !$past(oea_n))) else $error("a_oe");   // R7

    AST_OE_B_REG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (b_oe == !$past(oeb_n))) else $error("b_oe");   // R7

endmodule

// File: rtl/nwx_exchanger.sv
// Module nwx_exchanger
// Purpose : top of the registered narrow-to-wide bus exchanger.
//           Wires the two data paths and the output-enable registers together.
// Assumes : each three-state port is split into a data output, a drive enable
//           and a sampled input, with the pads outside this block.
module nwx_exchanger
    import nwx_pkg::*;
#(
    parameter int  W         = NWX_NARROW_W,
    parameter bit  USE_RESET = 1'b1,
    localparam int WW        = W * NWX_HALVES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  a_in,
    output logic [W-1:0]  a_out,
    output logic          a_oe,
    input  logic [WW-1:0] b_in,
    output logic [WW-1:0] b_out,
    output logic          b_oe,
    input  logic          ce_a1_n,
    input  logic          ce_ab_n,
    input  logic          ce_ba1_n,
    input  logic          ce_ba2_n,
    input  logic          sel_2b,
    input  logic          oea_n,
    input  logic          oeb_n
);

    logic [W-1:0] wide_hi;
    logic [W-1:0] wide_lo;

    // Narrow-to-wide path.
    nwx_a2b_path #(.W(W)) u_a2b (
        .clk        (clk),
        .rst_n      (rst_n),
        .a_in       (a_in),
        .ce_front_n (ce_a1_n),
        .ce_wide_n  (ce_ab_n),
        .wide_hi    (wide_hi),
        .wide_lo    (wide_lo)
    );

    // Wide-to-narrow path.
    nwx_b2a_path #(.W(W)) u_b2a (
        .clk     (clk),
        .rst_n   (rst_n),
        .b_in    (b_in),
        .ce_1b_n (ce_ba1_n),
        .ce_2b_n (ce_ba2_n),
        .sel_2b  (sel_2b),
        .a_out   (a_out)
    );

    // Registered output enables.
    nwx_oe_ctrl #(.USE_RESET(USE_RESET)) u_oe (
        .clk   (clk),
        .rst_n (rst_n),
        .oea_n (oea_n),
        .oeb_n (oeb_n),
        .a_oe  (a_oe),
        .b_oe  (b_oe)
    );

    // Assemble the wide output: 1B in the upper half, 2B in the lower half.
    always_comb begin
        b_out = {wide_hi, wide_lo};
    end

    AST_WIDE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_ab_n |=> (b_out[W-1:0] == $past(a_in))) else $error("order");   // R1

endmodule

// File: tb/tb_nwx_exchanger.sv
// Bench for nwx_exchanger.
// Mixes directed corner cases with seeded random traffic.
// Every output is compared against a bench model that follows the requirements.
module tb_nwx_exchanger;

    localparam int W  = 12;
    localparam int WW = 24;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [W-1:0]  a_in;
    logic [W-1:0]  a_out;
    logic          a_oe;
    logic [WW-1:0] b_in;
    logic [WW-1:0] b_out;
    logic          b_oe;
    logic          ce_a1_n, ce_ab_n, ce_ba1_n, ce_ba2_n, sel_2b, oea_n, oeb_n;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Bench model state.
    logic [W-1:0] m_front, m_hi, m_lo, m_s1, m_s2;
    logic         m_sel, m_aoe, m_boe;

    nwx_exchanger dut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .ce_a1_n(ce_a1_n), .ce_ab_n(ce_ab_n),
        .ce_ba1_n(ce_ba1_n), .ce_ba2_n(ce_ba2_n), .sel_2b(sel_2b), .oea_n(oea_n), .oeb_n(oeb_n)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [WW-1:0] got, input logic [WW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Expected narrow output: select 0 picks the 1B store, 1 picks the 2B store (R1).
    function automatic logic [W-1:0] exp_a();
        return m_sel ? m_s2 : m_s1;
    endfunction

    // Advance one cycle: update the model at the rising edge, then compare at the falling edge.
    task automatic tick();
        @(posedge clk);
        if (!ce_ab_n) begin
            m_hi = m_front;
            m_lo = a_in;
        end
        if (!ce_a1_n)  m_front = a_in;
        if (!ce_ba1_n) m_s1 = b_in[WW-1:W];
        if (!ce_ba2_n) m_s2 = b_in[W-1:0];
        m_sel = sel_2b;
        if (!rst_n) begin
            m_aoe = 1'b0;
            m_boe = 1'b0;
        end else begin
            m_aoe = !oea_n;
            m_boe = !oeb_n;
        end
        @(negedge clk);
        chk("R3 b_out", b_out, {m_hi, m_lo});
        chk("R5 a_out", {12'h0, a_out}, {12'h0, exp_a()});
        chk("R7 a_oe", {23'h0, a_oe}, {23'h0, m_aoe});
        chk("R7 b_oe", {23'h0, b_oe}, {23'h0, m_boe});
    endtask

    task automatic idle();
        ce_a1_n = 1; ce_ab_n = 1; ce_ba1_n = 1; ce_ba2_n = 1;
    endtask

    // Watchdog: a hung run counts as a failed check and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));

        // Reset with every store loaded so that nothing starts undefined.
        rst_n = 0; a_in = 12'h111; b_in = 24'h222333;
        ce_a1_n = 0; ce_ab_n = 0; ce_ba1_n = 0; ce_ba2_n = 0;
        sel_2b = 0; oea_n = 0; oeb_n = 0;
        repeat (3) tick();
        chk("R8 a_oe reset", {23'h0, a_oe}, 24'h0);
        chk("R8 b_oe reset", {23'h0, b_oe}, 24'h0);

        // The stores still loaded during reset, so data is unaffected by it (R8).
        chk("R8 data not reset", {12'h0, a_out}, 24'h000222);
        rst_n = 1; idle(); oea_n = 1; oeb_n = 1;
        tick();

        // X then Y gives {X, Y} on the wide port (R4).
        a_in = 12'hABC; ce_a1_n = 0; tick();
        a_in = 12'h123; ce_a1_n = 1; ce_ab_n = 0; tick();
        chk("R4 pair", b_out, 24'hABC123);

        // Upper half is 1B and carries X; lower half is 2B and carries Y (R1).
        chk("R1 hi half", {12'h0, b_out[23:12]}, 24'h000ABC);
        ce_ab_n = 1;

        // Front register holds while its enable is high (R2).
        a_in = 12'h5A5; ce_a1_n = 0; tick();
        ce_a1_n = 1; a_in = 12'hFFF; tick();
        a_in = 12'h0F0; tick();
        ce_ab_n = 0; tick();
        chk("R2 front hold", b_out, 24'h5A50F0);
        ce_ab_n = 1; a_in = 12'h777; tick();
        chk("R3 hold", b_out, 24'h5A50F0);

        // Select change takes effect only after the next edge (R6).
        b_in = 24'hC0FFEE; ce_ba1_n = 0; ce_ba2_n = 0; sel_2b = 0; tick();
        idle(); tick();
        sel_2b = 1; #1;
        chk("R6 sel before edge", {12'h0, a_out}, 24'h000C0F);
        tick();
        chk("R6 sel after edge", {12'h0, a_out}, 24'h000FEE);

        // Per-half enables for the wide-to-narrow stores (R5).
        b_in = 24'h123456; ce_ba2_n = 0; tick();
        ce_ba2_n = 1; sel_2b = 0; tick();
        chk("R5 1B kept", {12'h0, a_out}, 24'h000C0F);

        // Output enable change takes effect only after the next edge (R7).
        oea_n = 0; #1;
        chk("R7 a_oe before edge", {23'h0, a_oe}, 24'h0);
        tick();
        chk("R7 a_oe after edge", {23'h0, a_oe}, 24'h1);
        oeb_n = 0; #1;
        chk("R7 b_oe before edge", {23'h0, b_oe}, 24'h0);
        tick();

        // Seeded random traffic against the model.
        for (int i = 0; i < 2000; i++) begin
            a_in     = 12'($urandom);
            b_in     = 24'($urandom);
            ce_a1_n  = ($urandom % 3) == 0;
            ce_ab_n  = ($urandom % 3) == 0;
            ce_ba1_n = ($urandom % 2) == 0;
            ce_ba2_n = ($urandom % 2) == 0;
            sel_2b   = 1'($urandom);
            oea_n    = 1'($urandom);
            oeb_n    = 1'($urandom);
            rst_n    = ($urandom % 50) != 0;
            tick();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule